// File: doc/BRIEF.md
# Sampled Pulse Peak Timing Detector

This block watches a stream of 12-bit digitized detector samples, one per clock when a valid strobe is high. It averages each new sample with its recent neighbours to suppress noise, opens an event when the averaged signal climbs above a programmable threshold, and then hunts for local maxima. It declares a maximum where the slope turns from rising to not rising and the curvature is negative.

Every maximum is stored as an amplitude together with a time tag in a 16-entry result memory. The time tag is a count of averaged samples since the last readout clear. An inactivity timeout, restarted by each maximum found, closes the event and raises an end flag. Software-side logic reads the stored entries through a simple synchronous read port. It then pulses a clear input before the next acquisition.

Top module: `pulse_peak_timer`

## Requirements
- R1: With `cfg_avg3`=0 each valid input sample x[n] yields the averaged value floor((x[n]+x[n-1])/2). The sample history is zero after reset.
- R2: With `cfg_avg3`=1 each valid input sample yields floor((x[n]+x[n-1]+x[n-2])/3).
- R3: While no event is open, an averaged sample strictly above `cfg_threshold` opens an event. That sample receives the current time count, and the count then advances by one for it and for every later averaged sample of the event. The count holds between events.
- R4: While an event is open, the previous averaged sample y[k-1] is a peak when it belongs to the event, y[k-1] > y[k-2] and y[k] <= y[k-1]. On a flat top, only the first sample of the top is taken.
- R5: A peak is stored as the entry {amplitude in bits 27:16, time tag in bits 15:0}. The time tag is the count that the peak sample itself received.
- R6: Every averaged step of an open event that finds no peak advances a timeout count, and a step that finds a peak restarts it. When the count reaches `cfg_timeout` (0 acts as 1), the event closes and `event_end` goes high.
- R7: `event_end` stays high until the next event opens or `clr_readout` is pulsed.
- R8: Entries fill addresses 0 upward in detection order, and `peak_count` gives the number stored.
- R9: Once 16 entries are stored, further peaks are dropped, `overflow` goes high and stays high, and the stored entries are unchanged.
- R10: `clr_readout` zeroes `peak_count`, `overflow`, the time count and `event_end` and closes any open event. It takes priority over activity in the same cycle.
- R11: `rd_data` shows the entry at `rd_addr` one clock after the address is applied.
- R12: Cycles with `s_valid` low change nothing, so gaps in the stream leave the results unchanged.
- R13: After reset, `peak_count`, `overflow` and `event_end` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_avg3 | input | 1 | 1 selects 3-sample average, 0 selects 2-sample average |
| cfg_threshold | input | 12 | Level the averaged signal must exceed to open an event |
| cfg_timeout | input | 12 | Number of peakless averaged steps that closes an event |
| clr_readout | input | 1 | Start-of-readout clear |
| s_valid | input | 1 | Input sample strobe |
| s_data | input | 12 | Input sample |
| rd_addr | input | 4 | Result memory read address |
| rd_data | output | 28 | Registered result entry {amplitude, time} |
| peak_count | output | 5 | Number of stored peaks |
| overflow | output | 1 | A peak was dropped because the memory was full |
| event_end | output | 1 | Timeout closed the last event |

## Verification
The checker assumes that `clr_readout` is only pulsed after the stream has paused for a few cycles, so that no peak decision is still in the pipeline. It also assumes that the configuration inputs stay steady while samples flow. Under these assumptions, the stored-peak count can only stay put or rise by one per clock, and it stays frozen once an event has closed. The bench keeps within these assumptions: it changes configuration only while `s_valid` is low, and it idles before each clear. It checks stored amplitudes and time tags against a sample-by-sample model of the requirements. This includes runs with gaps in the strobe, a flat-topped pulse, a stream whose averaged height stays below threshold, and a burst that overfills the memory.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  // Fixed-point reciprocal of three: floor(s*RECIP3 >> RECIP_SH) == floor(s/3) for s < 32768.
  localparam int RECIP_SH = 16;
  localparam int RECIP3   = 21846;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } ppt_state_e;
endpackage

// File: rtl/ppt_smoother.sv
module ppt_smoother
  import ppt_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          avg3,
  output logic          y_valid,
  output logic [DW-1:0] y_data
);
  localparam int SW = DW + 2;
  localparam int PW = SW + RECIP_SH + 1;

  logic [DW-1:0] hist1, hist2;
  logic [SW-1:0] sum2, sum3;
  logic [PW-1:0] prod3;
  logic [DW-1:0] mean2, mean3;

  assign sum2  = SW'(in_data) + SW'(hist1);
  assign sum3  = SW'(in_data) + SW'(hist1) + SW'(hist2);
  assign prod3 = PW'(sum3) * PW'(RECIP3);
  assign mean2 = DW'(sum2 >> 1);
  assign mean3 = DW'(prod3 >> RECIP_SH);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist1   <= '0;
      hist2   <= '0;
      y_valid <= 1'b0;
      y_data  <= '0;
    end else begin
      y_valid <= in_valid;
      if (in_valid) begin
        hist2  <= hist1;
        hist1  <= in_data;
        y_data <= avg3 ? mean3 : mean2;
      end
    end
  end
endmodule

// File: rtl/ppt_event_ctrl.sv
module ppt_event_ctrl
  import ppt_pkg::*;
#(
  parameter int DW = 12,
  parameter int TW = 16,
  parameter int OW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step_valid,
  input  logic [DW-1:0] step_data,
  input  logic [DW-1:0] thr,
  input  logic [OW-1:0] tout_len,
  input  logic          pk_now,
  output logic          active,
  output logic          step_in_evt,
  output logic [TW-1:0] step_time,
  output logic          event_end
);
  ppt_state_e    state;
  logic [TW-1:0] tcnt;
  logic [OW-1:0] tout;
  logic [OW:0]   limit;
  logic          above;
  logic          expire;

  assign above       = step_data > thr;
  assign active      = (state == ST_ACTIVE);
  assign step_in_evt = active || above;
  assign step_time   = tcnt;
  assign limit       = (tout_len == '0) ? (OW+1)'(1) : {1'b0, tout_len};
  assign expire      = ({1'b0, tout} + (OW+1)'(1)) >= limit;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state     <= ST_IDLE;
      tcnt      <= '0;
      tout      <= '0;
      event_end <= 1'b0;
    end else if (step_valid) begin
      if (state == ST_IDLE) begin
        if (above) begin
          state     <= ST_ACTIVE;
          event_end <= 1'b0;
          tcnt      <= tcnt + 1'b1;
          tout      <= '0;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
        if (pk_now) begin
          tout <= '0;
        end else if (expire) begin
          state     <= ST_IDLE;
          event_end <= 1'b1;
        end else begin
          tout <= tout + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ppt_peak_finder.sv
module ppt_peak_finder #(
  parameter int DW = 12,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_valid,
  input  logic [DW-1:0] step_data,
  input  logic [TW-1:0] step_time,
  input  logic          step_in_evt,
  input  logic          test_en,
  output logic          pk_now,
  output logic          pk_valid,
  output logic [DW-1:0] pk_amp,
  output logic [TW-1:0] pk_time
);
  localparam int XW = DW + 3;

  logic [DW-1:0] y1, y2;
  logic [TW-1:0] t1;
  logic          e1;
  logic          rising, not_rising;
  logic [XW-1:0] curv;

  // curvature y[k] - 2*y[k-1] + y[k-2]; negative at a maximum
  assign curv       = XW'(step_data) + XW'(y2) - (XW'(y1) << 1);
  assign rising     = y1 > y2;
  assign not_rising = step_data <= y1;
  assign pk_now     = step_valid && test_en && e1 && rising && not_rising && curv[XW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      y1       <= '0;
      y2       <= '0;
      t1       <= '0;
      e1       <= 1'b0;
      pk_valid <= 1'b0;
      pk_amp   <= '0;
      pk_time  <= '0;
    end else begin
      pk_valid <= pk_now;
      if (pk_now) begin
        pk_amp  <= y1;
        pk_time <= t1;
      end
      if (step_valid) begin
        y2 <= y1;
        y1 <= step_data;
        t1 <= step_time;
        e1 <= step_in_evt;
      end
    end
  end
endmodule

// File: rtl/ppt_result_store.sv
module ppt_result_store #(
  parameter int AW    = 12,
  parameter int TW    = 16,
  parameter int DEPTH = 16,
  localparam int EW   = AW + TW,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_amp,
  input  logic [TW-1:0] wr_time,
  input  logic [PW-1:0] rd_addr,
  output logic [EW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          overflow
);
  logic [EW-1:0] mem [DEPTH];
  logic          has_room;
  logic          do_write;

  assign has_room = count < CW'(DEPTH);
  assign do_write = wr_en && !clr && has_room;

  // storage array without reset so that it maps to block RAM
  always_ff @(posedge clk) begin
    if (do_write) mem[count[PW-1:0]] <= {wr_amp, wr_time};
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (wr_en) begin
      if (has_room) count <= count + 1'b1;
      else          overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/pulse_peak_timer.sv
module pulse_peak_timer
  import ppt_pkg::*;
#(
  parameter int DW    = 12,
  parameter int TW    = 16,
  parameter int OW    = 12,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int EW   = DW + TW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_avg3,
  input  logic [DW-1:0] cfg_threshold,
  input  logic [OW-1:0] cfg_timeout,
  input  logic          clr_readout,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  input  logic [PW-1:0] rd_addr,
  output logic [EW-1:0] rd_data,
  output logic [CW-1:0] peak_count,
  output logic          overflow,
  output logic          event_end
);
  logic          y_valid;
  logic [DW-1:0] y_data;
  logic          active, in_evt, pk_now;
  logic [TW-1:0] step_time;
  logic          pk_valid;
  logic [DW-1:0] pk_amp;
  logic [TW-1:0] pk_time;

  ppt_smoother #(.DW(DW)) u_smooth (
    .clk     (clk),
    .rst     (rst),
    .in_valid(s_valid),
    .in_data (s_data),
    .avg3    (cfg_avg3),
    .y_valid (y_valid),
    .y_data  (y_data)
  );

  ppt_event_ctrl #(.DW(DW), .TW(TW), .OW(OW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr_readout),
    .step_valid (y_valid),
    .step_data  (y_data),
    .thr        (cfg_threshold),
    .tout_len   (cfg_timeout),
    .pk_now     (pk_now),
    .active     (active),
    .step_in_evt(in_evt),
    .step_time  (step_time),
    .event_end  (event_end)
  );

  ppt_peak_finder #(.DW(DW), .TW(TW)) u_peak (
    .clk        (clk),
    .rst        (rst),
    .step_valid (y_valid),
    .step_data  (y_data),
    .step_time  (step_time),
    .step_in_evt(in_evt),
    .test_en    (active),
    .pk_now     (pk_now),
    .pk_valid   (pk_valid),
    .pk_amp     (pk_amp),
    .pk_time    (pk_time)
  );

  ppt_result_store #(.AW(DW), .TW(TW), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_readout),
    .wr_en   (pk_valid),
    .wr_amp  (pk_amp),
    .wr_time (pk_time),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .count   (peak_count),
    .overflow(overflow)
  );
endmodule

// File: rtl/ppt_checker.sv
module ppt_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          clr_readout,
  input logic [CW-1:0] peak_count,
  input logic          overflow,
  input logic          event_end
);
  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    peak_count <= CW'(DEPTH));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr_readout)) |->
      (peak_count == $past(peak_count) || peak_count == $past(peak_count) + 1'b1));

  // R9
  ovf_full_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> peak_count == CW'(DEPTH));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(overflow) && !$past(clr_readout)) |-> overflow);

  // R10
  clr_effect_chk: assert property (@(posedge clk) disable iff (rst)
    clr_readout |=> (peak_count == '0 && !overflow && !event_end));

  // R6
  end_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(event_end) && event_end) |-> $stable(peak_count));
endmodule

bind pulse_peak_timer ppt_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_readout(clr_readout),
  .peak_count (peak_count),
  .overflow   (overflow),
  .event_end  (event_end)
);

// File: tb/tb_pulse_peak_timer.sv
module tb_pulse_peak_timer;
  localparam int BASE = 100;

  typedef struct packed {
    logic        avg3;
    logic [11:0] thr;
    logic [11:0] tout;
    logic [7:0]  npulse;
    logic [11:0] amp;
    logic [7:0]  gap;
    logic [3:0]  flat;
    logic        vgap;
    logic [4:0]  exp_cnt;
    logic        exp_ovf;
    logic        exp_end;
  } scn_t;

  localparam int NSCN = 7;
  localparam scn_t SCN [NSCN] = '{
    '{1'b0, 12'd300, 12'd8,  8'd1,  12'd800, 8'd0,  4'd0, 1'b0, 5'd1,  1'b0, 1'b1}, // R1 single pulse
    '{1'b1, 12'd300, 12'd30, 8'd3,  12'd600, 8'd2,  4'd0, 1'b0, 5'd3,  1'b0, 1'b1}, // R2 R4 three in one event
    '{1'b1, 12'd300, 12'd6,  8'd3,  12'd900, 8'd14, 4'd0, 1'b0, 5'd3,  1'b0, 1'b1}, // R3 R6 separate events
    '{1'b0, 12'd300, 12'd60, 8'd18, 12'd500, 8'd1,  4'd0, 1'b0, 5'd16, 1'b1, 1'b1}, // R9 overfill
    '{1'b1, 12'd900, 12'd8,  8'd2,  12'd500, 8'd3,  4'd0, 1'b0, 5'd0,  1'b0, 1'b0}, // R3 below threshold
    '{1'b0, 12'd300, 12'd20, 8'd1,  12'd700, 8'd0,  4'd5, 1'b0, 5'd1,  1'b0, 1'b1}, // R4 flat top
    '{1'b1, 12'd300, 12'd25, 8'd2,  12'd800, 8'd3,  4'd0, 1'b1, 5'd2,  1'b0, 1'b1}  // R12 strobe gaps
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_avg3;
  logic [11:0] cfg_threshold;
  logic [11:0] cfg_timeout;
  logic        clr_readout;
  logic        s_valid;
  logic [11:0] s_data;
  logic [3:0]  rd_addr;
  logic [27:0] rd_data;
  logic [4:0]  peak_count;
  logic        overflow;
  logic        event_end;

  always #2.5 clk = ~clk;

  pulse_peak_timer dut (
    .clk(clk), .rst(rst), .cfg_avg3(cfg_avg3), .cfg_threshold(cfg_threshold),
    .cfg_timeout(cfg_timeout), .clr_readout(clr_readout), .s_valid(s_valid),
    .s_data(s_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .peak_count(peak_count), .overflow(overflow), .event_end(event_end)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int mx1, mx2, my1, my2, mt1, mtc, mto, mcnt;
  bit ma1, mact, mend, movf;
  int ma [16];
  int mt [16];

  int stim [512];
  int slen;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0; mt1 = 0; ma1 = 0;
    mtc = 0; mto = 0; mact = 0; mend = 0; mcnt = 0; movf = 0;
  endtask

  task automatic model_clear();
    mcnt = 0; movf = 0; mtc = 0; mend = 0; mact = 0; mto = 0;
  endtask

  task automatic model_step(input int x);
    int y, tm, lim;
    bit ie, pk;
    if (cfg_avg3) y = (x + mx1 + mx2) / 3;
    else          y = (x + mx1) / 2;
    mx2 = mx1; mx1 = x;
    tm = mtc; ie = 0;
    lim = (cfg_timeout == 0) ? 1 : int'(cfg_timeout);
    if (!mact) begin
      if (y > int'(cfg_threshold)) begin
        mact = 1; mend = 0; ie = 1; mto = 0;
        mtc = (mtc + 1) & 16'hFFFF;
      end
    end else begin
      ie = 1;
      mtc = (mtc + 1) & 16'hFFFF;
      pk = ma1 && (my1 > my2) && (y <= my1);
      if (pk) begin
        if (mcnt < 16) begin ma[mcnt] = my1; mt[mcnt] = mt1; mcnt++; end
        else movf = 1;
        mto = 0;
      end else if (mto + 1 >= lim) begin
        mact = 0; mend = 1;
      end else begin
        mto++;
      end
    end
    my2 = my1; my1 = y; mt1 = tm; ma1 = ie;
  endtask

  task automatic feed(input int x, input bit gap);
    if (gap) begin
      @(negedge clk);
      s_valid = 1'b0;
    end
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = 12'(x);
    model_step(x);
  endtask

  task automatic settle(input int n);
    @(negedge clk);
    s_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int x);
    stim[slen] = x;
    slen++;
  endtask

  task automatic build(input scn_t s);
    slen = 0;
    for (int i = 0; i < 6; i++) push(BASE);
    for (int p = 0; p < int'(s.npulse); p++) begin
      for (int i = 1; i <= 4; i++) push(BASE + int'(s.amp) * i / 4);
      for (int i = 0; i < int'(s.flat); i++) push(BASE + int'(s.amp));
      for (int i = 3; i >= 0; i--) push(BASE + int'(s.amp) * i / 4);
      if (p != int'(s.npulse) - 1)
        for (int i = 0; i < int'(s.gap); i++) push(BASE);
    end
    for (int i = 0; i < int'(s.tout) + 24; i++) push(BASE);
  endtask

  task automatic read_entry(input int idx, output logic [27:0] d);
    @(negedge clk);
    rd_addr = 4'(idx);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic compare_entries(input string req);
    logic [27:0] d, e;
    for (int i = 0; i < mcnt; i++) begin
      read_entry(i, d);
      e = {12'(ma[i]), 16'(mt[i])};
      chk(d == e, req, int'(d), int'(e));
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr_readout = 1'b1;
    @(negedge clk);
    clr_readout = 1'b0;
    model_clear();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [27:0] d;
    rst = 1'b1; cfg_avg3 = 1'b0; cfg_threshold = 12'd300; cfg_timeout = 12'd8;
    clr_readout = 1'b0; s_valid = 1'b0; s_data = '0; rd_addr = '0;
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk(peak_count == 0, "R13 count", int'(peak_count), 0);
    chk(overflow == 0,   "R13 overflow", int'(overflow), 0);
    chk(event_end == 0,  "R13 end", int'(event_end), 0);

    // table of scenarios
    for (int r = 0; r < NSCN; r++) begin
      cfg_avg3      = SCN[r].avg3;
      cfg_threshold = SCN[r].thr;
      cfg_timeout   = SCN[r].tout;
      build(SCN[r]);
      for (int i = 0; i < slen; i++) feed(stim[i], SCN[r].vgap && (i % 3 == 1));
      settle(6);
      // R8 count against the hand-derived expectation and against the model
      chk(peak_count == SCN[r].exp_cnt, "R8 count vs table", int'(peak_count), int'(SCN[r].exp_cnt));
      chk(int'(peak_count) == mcnt, "R4 count vs model", int'(peak_count), mcnt);
      chk(overflow == SCN[r].exp_ovf, "R9 overflow", int'(overflow), int'(SCN[r].exp_ovf));
      chk(event_end == SCN[r].exp_end, "R6 end flag", int'(event_end), int'(SCN[r].exp_end));
      // R5 R11 stored amplitude and time per entry (R1 R2 through the amplitudes)
      compare_entries("R5 entry");
      do_clear();
      @(negedge clk);
      // R10 clear
      chk(peak_count == 0 && overflow == 0 && event_end == 0, "R10 clear",
          int'({peak_count, overflow, event_end}), 0);
    end

    // directed: end flag persistence and restart, time count held between events
    cfg_avg3 = 1'b0; cfg_threshold = 12'd300; cfg_timeout = 12'd8;
    for (int i = 0; i < 6; i++) feed(BASE, 1'b0);
    feed(300, 1'b0); feed(600, 1'b0); feed(900, 1'b0); feed(600, 1'b0); feed(300, 1'b0);
    for (int i = 0; i < 30; i++) feed(BASE, 1'b0);
    settle(4);
    chk(event_end == 1, "R6 timeout end", int'(event_end), 1);
    for (int i = 0; i < 10; i++) feed(BASE, 1'b0);
    settle(4);
    chk(event_end == 1, "R7 end held on quiet input", int'(event_end), 1);
    feed(700, 1'b0); feed(700, 1'b0);
    settle(3);
    chk(event_end == mend, "R7 end drops on new start", int'(event_end), int'(mend));
    chk(event_end == 0, "R7 end low after start", int'(event_end), 0);
    feed(900, 1'b0); feed(500, 1'b0);
    for (int i = 0; i < 30; i++) feed(BASE, 1'b0);
    settle(6);
    chk(int'(peak_count) == mcnt && mcnt == 2, "R3 two events", int'(peak_count), 2);
    compare_entries("R3 held time count");

    // directed: clear in the middle of an open event
    do_clear();
    for (int i = 0; i < 6; i++) feed(BASE, 1'b0);
    feed(500, 1'b0); feed(900, 1'b0);
    settle(4);
    do_clear();
    @(negedge clk);
    chk(peak_count == 0 && event_end == 0, "R10 clear mid event",
        int'({peak_count, event_end}), 0);
    for (int i = 0; i < 20; i++) feed(BASE, 1'b0);
    settle(6);
    chk(int'(peak_count) == mcnt, "R10 after clear count", int'(peak_count), mcnt);
    chk(event_end == mend, "R10 after clear end", int'(event_end), int'(mend));

    // R11 read latency: address change visible exactly one clock later
    read_entry(0, d);
    chk(rd_data == d, "R11 read stable", int'(rd_data), int'(d));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule